// File: doc/BRIEF.md
# Sampled-Clock Register Emulator

This block stands in for an ordinary edge-triggered register in a design that must run entirely on one fast global clock. The design clock, the reset and the per-bit set and clear lines all arrive as plain data inputs that are sampled on every global cycle. The block finds design-clock edges by comparing each sample with the one before it. It then rebuilds the register output on every global cycle from its stored copies of the previous D and the previous Q.

A parameter selects one of three variants. The plain variant is a simple register. The reset variant adds an asynchronous reset that forces a constant value. The set/clear variant adds per-bit asynchronous set and clear. The asynchronous controls act combinationally on Q in the same global cycle they are seen. The clock polarity, the reset polarity, the set polarity, the clear polarity, the reset value and a power-up value are all parameters. No back-pressure applies: every pin is a plain level that is sampled on every global cycle, so there is no valid/ready interface.

Top module: `gclk_reg_emu`

## Requirements
- R1: At power-up the stored previous design-clock sample equals the active level, so no edge is seen in the first global cycle. Both the stored D and the stored Q start at INIT_VALUE for the bits set in INIT_KNOWN.
- R2: An edge is a global cycle in which the sampled design clock is at its active level and the previous sample was not. The active level is 1 when CLK_RISING=1 and 0 when CLK_RISING=0. In an edge cycle the clocked value equals D as sampled in the previous global cycle.
- R3: In a global cycle with no edge, the clocked value equals Q from the previous global cycle.
- R4: The reset variant keeps a one-cycle copy of the reset input. Reset is in force when either the current sample or the stored copy is at the active reset level (1 when RST_HIGH=1, 0 when RST_HIGH=0). A one-cycle reset pulse therefore holds Q at RST_VALUE for two global cycles.
- R5: While reset is in force, Q equals RST_VALUE in the same global cycle, whatever the design clock does.
- R6: In the set/clear variant, every bit whose set line is active reads 1 on Q in the same global cycle, unless its clear line is also active.
- R7: Clear wins over set: every bit whose clear line is active reads 0 on Q.
- R8: Set and clear each have their own polarity parameter (SET_HIGH, CLR_HIGH; 1 means active-high). Each is normalized before the two are combined.
- R9: After reset is released, Q keeps RST_VALUE until the next edge. The set/clear variant likewise keeps forced bits after their control is released, until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| gclk | input | 1 | Global clock; the only true clock |
| dclk | input | 1 | Emulated design clock, sampled as data |
| d | input | WIDTH | Register data input |
| rst | input | 1 | Asynchronous reset (reset variant), polarity set by RST_HIGH |
| set | input | WIDTH | Per-bit asynchronous set (set/clear variant), polarity set by SET_HIGH |
| clr | input | WIDTH | Per-bit asynchronous clear (set/clear variant), polarity set by CLR_HIGH |
| q | output | WIDTH | Emulated register output |

## Verification
The hardest case to reach is the interaction between the stored reset copy and a design-clock edge. A reset that lasts one global cycle must still mask an edge in the following cycle. After that, Q must stay at the reset value rather than pick up the D that was present during the reset. The stimulus gives the design clock random toggle timing, fires short reset, set and clear pulses at random, and adds a directed pulse placed right before a rising edge. A behavioural register model in the bench predicts every global cycle for four instances: a rising-edge plain register, a falling-edge plain register, an active-low reset register and a set/clear register.

// File: rtl/gre_pkg.sv
package gre_pkg;
  typedef enum logic [1:0] {
    GRE_PLAIN  = 2'd0,
    GRE_ARST   = 2'd1,
    GRE_SETCLR = 2'd2
  } gre_kind_e;
endpackage

// File: rtl/gre_hold.sv
// One global-cycle delay stage with a power-up value; unknown bits stay X.
module gre_hold #(
  parameter int W = 1,
  parameter logic [W-1:0] INIT  = '0,
  parameter logic [W-1:0] KNOWN = '1
) (
  input  logic         gclk,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam logic [W-1:0] PWR = (INIT & KNOWN) | ({W{1'bx}} & ~KNOWN);

  logic [W-1:0] held = PWR;

  always_ff @(posedge gclk) held <= din;

  assign dout = held;
endmodule

// File: rtl/gre_edge.sv
// Recovers design-clock edges from consecutive global-cycle samples.
module gre_edge #(
  parameter bit CLK_RISING = 1'b1
) (
  input  logic gclk,
  input  logic dclk,
  output logic hit
);
  localparam logic ACT = CLK_RISING;

  logic prev_clk;

  gre_hold #(.W(1), .INIT(ACT), .KNOWN(1'b1)) u_prev (
    .gclk (gclk),
    .din  (dclk),
    .dout (prev_clk)
  );

  // previous inactive, current active
  assign hit = (prev_clk == ~ACT) && (dclk == ACT);
endmodule

// File: rtl/gre_ctrl.sv
// Applies asynchronous controls to the clocked value; both forms computed.
module gre_ctrl #(
  parameter int W = 8,
  parameter bit RST_HIGH = 1'b1,
  parameter logic [W-1:0] RST_VALUE = '0,
  parameter bit SET_HIGH = 1'b1,
  parameter bit CLR_HIGH = 1'b1
) (
  input  logic         gclk,
  input  logic [W-1:0] clocked,
  input  logic         rst,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q_rst,
  output logic [W-1:0] q_sc
);
  localparam logic RST_IDLE = ~RST_HIGH;

  logic rst_prev;
  logic rst_eff;
  logic [W-1:0] set_on;
  logic [W-1:0] clr_keep;

  gre_hold #(.W(1), .INIT(RST_IDLE), .KNOWN(1'b1)) u_rst_prev (
    .gclk (gclk),
    .din  (rst),
    .dout (rst_prev)
  );

  generate
    if (RST_HIGH) begin : g_rst_hi
      assign rst_eff = rst | rst_prev;
    end else begin : g_rst_lo
      assign rst_eff = ~(rst & rst_prev);
    end
  endgenerate

  assign q_rst = rst_eff ? RST_VALUE : clocked;

  assign set_on   = SET_HIGH ? set : ~set;
  assign clr_keep = CLR_HIGH ? ~clr : clr;
  assign q_sc     = (clocked | set_on) & clr_keep;
endmodule

// File: rtl/gclk_reg_emu.sv
module gclk_reg_emu #(
  parameter int WIDTH = 8,
  parameter gre_pkg::gre_kind_e KIND = gre_pkg::GRE_PLAIN,
  parameter bit CLK_RISING = 1'b1,
  parameter bit RST_HIGH = 1'b1,
  parameter logic [WIDTH-1:0] RST_VALUE = '0,
  parameter bit SET_HIGH = 1'b1,
  parameter bit CLR_HIGH = 1'b1,
  parameter logic [WIDTH-1:0] INIT_VALUE = '0,
  parameter logic [WIDTH-1:0] INIT_KNOWN = '1
) (
  input  logic             gclk,
  input  logic             dclk,
  input  logic [WIDTH-1:0] d,
  input  logic             rst,
  input  logic [WIDTH-1:0] set,
  input  logic [WIDTH-1:0] clr,
  output logic [WIDTH-1:0] q
);
  localparam logic ACT = CLK_RISING;

  logic             hit;
  logic [WIDTH-1:0] d_prev;
  logic [WIDTH-1:0] q_prev;
  logic [WIDTH-1:0] clocked;
  logic [WIDTH-1:0] q_rst;
  logic [WIDTH-1:0] q_sc;

  gre_edge #(.CLK_RISING(CLK_RISING)) u_edge (
    .gclk (gclk),
    .dclk (dclk),
    .hit  (hit)
  );

  gre_hold #(.W(WIDTH), .INIT(INIT_VALUE), .KNOWN(INIT_KNOWN)) u_dprev (
    .gclk (gclk),
    .din  (d),
    .dout (d_prev)
  );

  gre_hold #(.W(WIDTH), .INIT(INIT_VALUE), .KNOWN(INIT_KNOWN)) u_qprev (
    .gclk (gclk),
    .din  (q),
    .dout (q_prev)
  );

  assign clocked = hit ? d_prev : q_prev;

  gre_ctrl #(
    .W(WIDTH), .RST_HIGH(RST_HIGH), .RST_VALUE(RST_VALUE),
    .SET_HIGH(SET_HIGH), .CLR_HIGH(CLR_HIGH)
  ) u_ctrl (
    .gclk    (gclk),
    .clocked (clocked),
    .rst     (rst),
    .set     (set),
    .clr     (clr),
    .q_rst   (q_rst),
    .q_sc    (q_sc)
  );

  // warm gates assertions until one global edge has passed
  logic warm = 1'b0;
  always_ff @(posedge gclk) warm <= 1'b1;

  generate
    if (KIND == gre_pkg::GRE_ARST) begin : g_arst
      assign q = q_rst;
      logic rst_on;
      assign rst_on = (rst == RST_HIGH);

      a_r5_reset_forces_value: assert property (@(posedge gclk) disable iff (!warm)
        rst_on |-> (q == RST_VALUE));
      a_r4_reset_stretched: assert property (@(posedge gclk) disable iff (!warm)
        $past(rst_on) |-> (q == RST_VALUE));
    end else if (KIND == gre_pkg::GRE_SETCLR) begin : g_setclr
      assign q = q_sc;
      logic [WIDTH-1:0] set_act;
      logic [WIDTH-1:0] clr_act;
      assign set_act = SET_HIGH ? set : ~set;
      assign clr_act = CLR_HIGH ? clr : ~clr;

      a_r7_clear_wins: assert property (@(posedge gclk) disable iff (!warm)
        ((q & clr_act) == '0));
      a_r6_set_forces_one: assert property (@(posedge gclk) disable iff (!warm)
        ((q & set_act & ~clr_act) == (set_act & ~clr_act)));
    end else begin : g_plain
      assign q = clocked;

      a_r2_edge_loads_d: assert property (@(posedge gclk) disable iff (!warm)
        (($past(dclk) != ACT) && (dclk == ACT)) |-> (q == $past(d)));
      a_r3_no_edge_holds: assert property (@(posedge gclk) disable iff (!warm)
        (dclk == $past(dclk)) |-> (q == $past(q)));
    end
  endgenerate
endmodule

// File: tb/gclk_reg_emu_test.sv
`timescale 1ns/1ps
module gclk_reg_emu_test;
  localparam int W = 8;
  localparam logic [W-1:0] INIT = 8'h3C;
  localparam logic [W-1:0] RV   = 8'hA5;
  localparam int N4 = 4 * W;

  logic gclk = 1'b0;
  always #5 gclk = ~gclk;

  logic         dclk  = 1'b0;
  logic [W-1:0] d     = '0;
  logic         rst_n = 1'b1;
  logic [W-1:0] set   = '0;
  logic [W-1:0] clr_n = '1;

  logic [W-1:0] q_plain, q_fall, q_rst, q_sc;

  int total = 0;
  int bad = 0;

  gclk_reg_emu #(.WIDTH(W), .KIND(gre_pkg::GRE_PLAIN), .CLK_RISING(1'b1),
    .INIT_VALUE(INIT)) uut (
    .gclk(gclk), .dclk(dclk), .d(d), .rst(1'b0), .set('0), .clr('0), .q(q_plain));

  gclk_reg_emu #(.WIDTH(W), .KIND(gre_pkg::GRE_PLAIN), .CLK_RISING(1'b0),
    .INIT_VALUE(INIT)) uut_fall (
    .gclk(gclk), .dclk(dclk), .d(d), .rst(1'b0), .set('0), .clr('0), .q(q_fall));

  gclk_reg_emu #(.WIDTH(W), .KIND(gre_pkg::GRE_ARST), .CLK_RISING(1'b1),
    .RST_HIGH(1'b0), .RST_VALUE(RV), .INIT_VALUE(INIT)) uut_rst (
    .gclk(gclk), .dclk(dclk), .d(d), .rst(rst_n), .set('0), .clr('0), .q(q_rst));

  gclk_reg_emu #(.WIDTH(W), .KIND(gre_pkg::GRE_SETCLR), .CLK_RISING(1'b1),
    .SET_HIGH(1'b1), .CLR_HIGH(1'b0), .INIT_VALUE(INIT)) uut_sc (
    .gclk(gclk), .dclk(dclk), .d(d), .rst(1'b0), .set(set), .clr(clr_n), .q(q_sc));

  // behavioural model state: previous samples as a real register sees them
  logic         m_clk_r = 1'b1;
  logic         m_clk_f = 1'b0;
  logic [W-1:0] m_d     = INIT;
  logic         m_rstn  = 1'b1;
  logic [W-1:0] m_q_plain = INIT, m_q_fall = INIT, m_q_rst = INIT, m_q_sc = INIT;
  logic [W-1:0] e_plain = INIT, e_fall = INIT, e_rst = INIT, e_sc = INIT;

  logic [N4-1:0] sb[$];

  task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: apply inputs away from the edge, predict outputs, push to scoreboard
  task automatic step(input logic c, input logic [W-1:0] dv, input logic rn,
                      input logic [W-1:0] sv, input logic [W-1:0] cn);
    logic rise, fall;
    logic [W-1:0] clk_r;
    @(negedge gclk);
    dclk = c; d = dv; rst_n = rn; set = sv; clr_n = cn;
    rise = (m_clk_r == 1'b0) && (c == 1'b1);
    fall = (m_clk_f == 1'b1) && (c == 1'b0);
    e_plain = rise ? m_d : m_q_plain;
    e_fall  = fall ? m_d : m_q_fall;
    clk_r   = rise ? m_d : m_q_rst;
    e_rst   = (!rn || !m_rstn) ? RV : clk_r;
    e_sc    = ((rise ? m_d : m_q_sc) | sv) & cn;
    sb.push_back({e_plain, e_fall, e_rst, e_sc});
  endtask

  always @(posedge gclk) begin
    m_clk_r = dclk; m_clk_f = dclk; m_d = d; m_rstn = rst_n;
    m_q_plain = e_plain; m_q_fall = e_fall; m_q_rst = e_rst; m_q_sc = e_sc;
  end

  // monitor: pop and compare well before the next rising global edge
  always @(negedge gclk) begin
    #3;
    if (sb.size() > 0) begin
      logic [N4-1:0] e;
      e = sb.pop_front();
      check(q_plain, e[4*W-1:3*W], "R2 R3 plain rising");
      check(q_fall,  e[3*W-1:2*W], "R2 R3 plain falling");
      check(q_rst,   e[2*W-1:W],   "R4 R5 R9 reset");
      check(q_sc,    e[W-1:0],     "R6 R7 R8 set/clear");
    end
  end

  initial begin
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic c;
    #2;
    // R1: power-up values, no edge before the first global edge
    check(q_plain, INIT, "R1 plain");
    check(q_fall,  INIT, "R1 falling");
    check(q_rst,   INIT, "R1 reset");
    check(q_sc,    INIT, "R1 set/clear");

    // R2 R3: regular design clock, changing data
    c = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (i % 3 == 0) c = ~c;
      step(c, W'(i * 37 + 5), 1'b1, '0, '1);
    end

    // R4 R9: single-cycle reset pulse just before a rising edge
    step(1'b0, 8'h11, 1'b1, '0, '1);
    step(1'b0, 8'h22, 1'b0, '0, '1);
    step(1'b1, 8'h33, 1'b1, '0, '1);
    step(1'b1, 8'h44, 1'b1, '0, '1);
    step(1'b0, 8'h55, 1'b1, '0, '1);
    step(1'b1, 8'h66, 1'b1, '0, '1);

    // R6 R7 R8: overlapping set and clear with the clock idle
    step(1'b1, 8'h00, 1'b1, 8'hF0, 8'h3F);
    step(1'b1, 8'h00, 1'b1, 8'h00, 8'hFF);

    // random timing of clock and controls
    for (int i = 0; i < 2500; i++) begin
      logic [W-1:0] sv, cn;
      logic rn;
      if ($urandom_range(0, 2) == 0) c = ~c;
      rn = ($urandom_range(0, 15) != 0);
      sv = ($urandom_range(0, 7) == 0) ? W'($urandom) : '0;
      cn = ($urandom_range(0, 7) == 0) ? W'($urandom) : '1;
      step(c, W'($urandom), rn, sv, cn);
    end

    @(negedge gclk);
    #5;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule